// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block holds the interrupt bookkeeping for one 8-bit timer/counter that has a single compare channel. Two event pulses come from the counter: a compare-match pulse, and an overflow pulse or a bottom-reversal pulse. A mode input says whether the counter runs in up/down PWM mode. That mode decides which of the two pulses sets the overflow flag.

Software reaches two registers through a simple register bus. The enable register holds one enable bit per source. The flag register holds one pending flag per source. A flag is cleared when software writes a one to its bit, or when the interrupt controller acknowledges the vector for that source. Each source drives its own request line. The line is registered, and it is high only while the global interrupt enable, the source's enable bit and its flag are all set.

Top module: `tmr_irq_unit`

## Requirements
- R1: After a synchronous reset, the enable bits, the flags, both request lines and the read data are all zero.
- R2: The enable register sits at bus address 0. Bit 1 enables the compare source and bit 0 enables the overflow source. Bits 7 to 2 always read as zero.
- R3: The flag register sits at bus address 1, with the compare flag at bit 1. A cycle with `cmp_match_i` high sets the compare flag on that clock edge.
- R4: When `pwm_updown_i` is low, a cycle with `cnt_ovf_i` high sets the overflow flag (bit 0), and `cnt_bottom_rev_i` has no effect.
- R5: When `pwm_updown_i` is high, a cycle with `cnt_bottom_rev_i` high sets the overflow flag, and `cnt_ovf_i` has no effect.
- R6: A bus write to address 1 clears each flag whose data bit is one. A zero data bit leaves its flag unchanged.
- R7: `ack_i[1]` clears the compare flag and `ack_i[0]` clears the overflow flag on that clock edge.
- R8: A set event for a flag takes priority over a write-one clear or an acknowledge for the same flag in the same cycle, so the flag ends as one.
- R9: `irq_o[i]` is the value of global enable AND enable bit i AND flag i as it stood before the previous clock edge. Clearing an enable bit drops the request one cycle later and leaves the flag unchanged.
- R10: A read strobe loads `bus_rdata_o` on the next edge with the register value from before that edge. A read to an unmapped address loads zero. The read data holds between reads, and reads never change a flag.
- R11: Writes to addresses 2 and 3 change neither the enable bits nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_match_i | input | 1 | Compare-match event pulse |
| cnt_ovf_i | input | 1 | Counter overflow pulse (normal modes) |
| cnt_bottom_rev_i | input | 1 | Direction change at zero pulse (up/down PWM) |
| pwm_updown_i | input | 1 | High while the counter runs in up/down PWM mode |
| gie_i | input | 1 | Global interrupt enable |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| ack_i | input | 2 | Per-source vector acknowledge (bit 1 compare, bit 0 overflow) |
| irq_o | output | 2 | Per-source request (bit 1 compare, bit 0 overflow) |

## Verification
The bench sweeps every combination of the two set pulses, the mode bit, both acknowledge bits, a flag write and both write-data bits, each from whatever flag state the previous step left behind. This keeps the set-over-clear priority apart from the plain clears, and keeps write-one clearing apart from acknowledge clearing. Running the same pulses with the mode bit low and high shows whether the overflow flag follows the right event. Between steps it reads the flag register back. Across the sweep, the global enable and the enable bits change so that the request gating is seen with every enable pattern. Directed steps cover the reserved bits, the unmapped addresses and reads that must leave a flag untouched.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NSRC = 2;
  typedef enum int {SRC_OVF = 0, SRC_CMP = 1} src_e;
endpackage

// File: rtl/tmr_irq_flag.sv
// One pending flag: set has priority over clear (R8).
module tmr_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/tmr_irq_regs.sv
// Enable register, flag write-one-clear decode and registered readback.
module tmr_irq_regs #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int NSRC   = 2,
  parameter logic [ADDR_W-1:0] MASK_ADDR = '0,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   flag_i,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   wclr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - NSRC;

  logic hit_mask, hit_flag;
  logic unused_wbits;

  assign hit_mask     = (addr_i == MASK_ADDR);
  assign hit_flag     = (addr_i == FLAG_ADDR);
  assign unused_wbits = ^wdata_i[DATA_W-1:NSRC];
  assign wclr_o       = (wr_i && hit_flag) ? wdata_i[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst)                   mask_o <= '0;
    else if (wr_i && hit_mask) mask_o <= wdata_i[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      if (hit_mask)      rdata_o <= {{PAD_W{1'b0}}, mask_o};
      else if (hit_flag) rdata_o <= {{PAD_W{1'b0}}, flag_i};
      else               rdata_o <= '0;
    end
  end
endmodule

// File: rtl/tmr_irq_req.sv
// Registered per-source request gating.
module tmr_irq_req #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gie_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] flag_i,
  output logic [NSRC-1:0] irq_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_req
    always_ff @(posedge clk) begin
      if (rst) irq_o[g] <= 1'b0;
      else     irq_o[g] <= gie_i & mask_i[g] & flag_i[g];
    end
  end
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] MASK_ADDR = '0,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cmp_match_i,
  input  logic                          cnt_ovf_i,
  input  logic                          cnt_bottom_rev_i,
  input  logic                          pwm_updown_i,
  input  logic                          gie_i,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic                          bus_wr_i,
  input  logic                          bus_rd_i,
  input  logic [DATA_W-1:0]             bus_wdata_i,
  output logic [DATA_W-1:0]             bus_rdata_o,
  input  logic [tmr_irq_pkg::NSRC-1:0]  ack_i,
  output logic [tmr_irq_pkg::NSRC-1:0]  irq_o
);
  import tmr_irq_pkg::*;

  logic [NSRC-1:0] set_evt, clr_evt, wclr, mask_q, flag_q;

  // Overflow flag source depends on counting mode (R4, R5).
  assign set_evt[SRC_CMP] = cmp_match_i;
  assign set_evt[SRC_OVF] = pwm_updown_i ? cnt_bottom_rev_i : cnt_ovf_i;
  assign clr_evt          = wclr | ack_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    tmr_irq_flag flag_i (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_evt[g]),
      .clr_i  (clr_evt[g]),
      .flag_o (flag_q[g])
    );
  end

  tmr_irq_regs #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NSRC      (NSRC),
    .MASK_ADDR (MASK_ADDR),
    .FLAG_ADDR (FLAG_ADDR)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .wdata_i (bus_wdata_i),
    .flag_i  (flag_q),
    .mask_o  (mask_q),
    .wclr_o  (wclr),
    .rdata_o (bus_rdata_o)
  );

  tmr_irq_req #(.NSRC(NSRC)) req_i (
    .clk    (clk),
    .rst    (rst),
    .gie_i  (gie_i),
    .mask_i (mask_q),
    .flag_i (flag_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_match_i,
  input logic              cnt_ovf_i,
  input logic              cnt_bottom_rev_i,
  input logic              pwm_updown_i,
  input logic              gie_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [1:0]        ack_i,
  input logic [1:0]        mask_q,
  input logic [1:0]        flag_q,
  input logic [1:0]        irq_o,
  input logic [DATA_W-1:0] bus_rdata_o
);
  logic flag_wr;
  assign flag_wr = bus_wr_i && (bus_addr_i == FLAG_ADDR);

  p_cmp_set_r3: assert property (@(posedge clk) disable iff (rst)
    cmp_match_i |=> flag_q[1]);
  p_ovf_normal_r4: assert property (@(posedge clk) disable iff (rst)
    (!pwm_updown_i && cnt_ovf_i) |=> flag_q[0]);
  p_bottom_pwm_r5: assert property (@(posedge clk) disable iff (rst)
    (pwm_updown_i && cnt_bottom_rev_i) |=> flag_q[0]);
  p_wr_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && bus_wdata_i[1] && !cmp_match_i) |=> !flag_q[1]);
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_i[1] && !cmp_match_i) |=> !flag_q[1]);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (cmp_match_i && (ack_i[1] || (flag_wr && bus_wdata_i[1]))) |=> flag_q[1]);
  p_irq_on_r9: assert property (@(posedge clk) disable iff (rst)
    (gie_i && mask_q[1] && flag_q[1]) |=> irq_o[1]);
  p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
    !(gie_i && mask_q[0] && flag_q[0]) |=> !irq_o[0]);
  p_read_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && !bus_wr_i && !ack_i[1] && !cmp_match_i) |=> $stable(flag_q[1]));

  always @(negedge clk) begin
    if (!rst) begin
      p_reserved_zero_r2: assert (bus_rdata_o[DATA_W-1:2] == '0);
    end
  end
endmodule

bind tmr_irq_unit tmr_irq_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .FLAG_ADDR (FLAG_ADDR)
) chk_i (
  .clk              (clk),
  .rst              (rst),
  .cmp_match_i      (cmp_match_i),
  .cnt_ovf_i        (cnt_ovf_i),
  .cnt_bottom_rev_i (cnt_bottom_rev_i),
  .pwm_updown_i     (pwm_updown_i),
  .gie_i            (gie_i),
  .bus_addr_i       (bus_addr_i),
  .bus_wr_i         (bus_wr_i),
  .bus_rd_i         (bus_rd_i),
  .bus_wdata_i      (bus_wdata_i),
  .ack_i            (ack_i),
  .mask_q           (mask_q),
  .flag_q           (flag_q),
  .irq_o            (irq_o),
  .bus_rdata_o      (bus_rdata_o)
);

// File: tb/tmr_irq_unit_tb_top.sv
module tmr_irq_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp = 0, ovf = 0, rev = 0, pwm = 0, gie = 0;
  logic [1:0] addr = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] wdata = 0;
  logic [1:0] ack = 0;
  logic [7:0] rdata;
  logic [1:0] irq;

  int n_chk = 0, n_fail = 0;
  logic [1:0] m_mask = 0, m_flag = 0, m_irq = 0;
  logic [7:0] m_rdata = 0;

  always #10 clk = ~clk;

  tmr_irq_unit dut_i (
    .clk (clk), .rst (rst),
    .cmp_match_i (cmp), .cnt_ovf_i (ovf), .cnt_bottom_rev_i (rev),
    .pwm_updown_i (pwm), .gie_i (gie),
    .bus_addr_i (addr), .bus_wr_i (wr), .bus_rd_i (rd),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata),
    .ack_i (ack), .irq_o (irq)
  );

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // One clock: model follows the requirements, inputs held stable across the edge.
  task automatic tick();
    logic [1:0] setv, clrv;
    @(posedge clk);
    m_irq = {2{gie}} & m_mask & m_flag;
    if (rd) m_rdata = (addr == 2'd0) ? {6'b0, m_mask} :
                      (addr == 2'd1) ? {6'b0, m_flag} : 8'h00;
    setv = {cmp, pwm ? rev : ovf};
    clrv = ack | ((wr && addr == 2'd1) ? wdata[1:0] : 2'b00);
    for (int b = 0; b < 2; b++)
      if (setv[b]) m_flag[b] = 1'b1; else if (clrv[b]) m_flag[b] = 1'b0;
    if (wr && addr == 2'd0) m_mask = wdata[1:0];
    @(negedge clk);
  endtask

  task automatic idle();
    cmp = 0; ovf = 0; rev = 0; ack = 0; wr = 0; rd = 0; wdata = 0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    idle(); addr = a; wr = 1; wdata = d; tick(); idle();
  endtask

  task automatic bus_read(input logic [1:0] a, input string tag);
    idle(); addr = a; rd = 1; tick(); idle();
    chk(rdata === m_rdata, tag, rdata, m_rdata);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: reset state
    chk(irq === 2'b00, "R1 irq", {6'b0, irq}, 8'h00);
    chk(rdata === 8'h00, "R1 rdata", rdata, 8'h00);
    rst = 0;
    bus_read(2'd1, "R1 flags");
    bus_read(2'd0, "R1 mask");

    // R2: enable register, reserved bits read zero
    bus_write(2'd0, 8'hFF);
    bus_read(2'd0, "R2 mask ff");
    chk(rdata === 8'h03, "R2 reserved", rdata, 8'h03);
    bus_write(2'd0, 8'hFE);
    bus_read(2'd0, "R2 mask fe");

    // R11: unmapped writes ignored, unmapped read gives zero
    cmp = 1; tick(); idle();
    bus_write(2'd2, 8'hFF);
    bus_write(2'd3, 8'h00);
    bus_read(2'd1, "R11 flag kept");
    bus_read(2'd0, "R11 mask kept");
    bus_read(2'd3, "R10 unmapped read zero");

    // R10: repeated reads leave flags alone and read data holds
    bus_read(2'd1, "R10 read1");
    bus_read(2'd1, "R10 read2");
    tick();
    chk(rdata === m_rdata, "R10 hold", rdata, m_rdata);

    // R9: enable drop removes request next cycle, flag kept
    gie = 1; bus_write(2'd0, 8'h02); tick();
    chk(irq === m_irq, "R9 irq on", {6'b0, irq}, {6'b0, m_irq});
    bus_write(2'd0, 8'h00);
    tick();
    chk(irq === m_irq, "R9 irq off", {6'b0, irq}, {6'b0, m_irq});
    bus_read(2'd1, "R9 flag kept");

    // Sweep: all event/clear combos, gie and mask varied
    for (int i = 0; i < 2048; i++) begin
      string tag;
      if (i[6:0] == 0) bus_write(2'd0, {6'b0, i[8:7]});
      gie = i[9];
      cmp = i[0]; ovf = i[1]; rev = i[2]; pwm = i[3];
      ack = i[5:4]; wr = i[6]; addr = 2'd1;
      wdata = {6'b0, i[8:7]} ^ {6'b0, i[10], 1'b0};
      if ((cmp && (ack[1] || (wr && wdata[1]))) ||
          ((pwm ? rev : ovf) && (ack[0] || (wr && wdata[0])))) tag = "R8 set wins";
      else if (ack != 0) tag = "R7 ack clear";
      else if (wr) tag = "R6 write clear";
      else if (pwm) tag = "R5 pwm bottom";
      else if (ovf || rev) tag = "R4 overflow";
      else tag = "R3 compare";
      tick(); idle();
      chk(irq === m_irq, "R9 sweep irq", {6'b0, irq}, {6'b0, m_irq});
      bus_read(2'd1, tag);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule